// File: doc/BRIEF.md
# Quarter-Wave Sine Oscillator with Phase-Shift Keying

This block is a numerically controlled oscillator that feeds a 10-bit offset-binary current-steering converter. A 32-bit phase accumulator advances by a programmable tuning word on every clock. A 2-bit modulation code adds a whole number of quarter turns to the phase, which lets a baseband encoder key the carrier in 90° steps.

Only the first quarter of the sine wave is kept, as a 256-entry magnitude table that is computed at elaboration. The two top phase bits pick the quadrant. In the falling quadrants the table is read with a mirrored address. For the lower half-cycle the oscillator clears the output sign bit and raises a separate invert flag. The converter front-end then complements the nine magnitude bits, which completes the negative half-wave without a second table.

Top module: `qwave_nco`

## Requirements
- R1: While reset is held and on the cycle it ends, `dac_code` is 514 (sign bit 1, magnitude 2 = table entry 0) and `dac_inv` is 0.
- R2: A write with `tw_we` high stores `tw_data` at that clock edge. The accumulator first adds the new word at the following edge.
- R3: The accumulator adds the stored tuning word once per clock, modulo 2^32, so a negative word (two's complement) turns the phase backwards across the wrap point.
- R4: `pm_code` adds quarter turns to the top 10 phase bits: 00 adds 0, 01 adds 256 (90°), 10 adds 768 (270°), 11 adds 512 (180°).
- R5: The modulated phase p is 10 bits. p[9:8] is the quadrant and p[7:0] is the table index. In quadrants 1 and 3 the index used is 255 minus p[7:0].
- R6: If p[9] is 0, `dac_code[9]` is 1 and `dac_inv` is 0. If p[9] is 1, `dac_code[9]` is 0 and `dac_inv` is 1. `dac_code[8:0]` always carries the table magnitude.
- R7: Table entry i is round(511·sin(π/2·(i+0.5)/256)). The effective code is `dac_code` with bits 8..0 complemented when `dac_inv` is 1. It stays within ±2 of 511.5 + 511.5·sin(2π·(p+0.5)/1024).
- R8: A `pm_code` value sampled at edge E, and an accumulator value produced at edge E, both reach the outputs at edge E+2. With the tuning word at zero, the output is steady once the code has been constant for two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tw_we | input | 1 | Tuning word write strobe |
| tw_data | input | 32 | Tuning word (phase increment per clock) |
| pm_code | input | 2 | Phase modulation code (quarter-turn offset) |
| dac_code | output | 10 | Converter data; bit 9 is the sign |
| dac_inv | output | 1 | Invert flag for bits 8..0 at the converter |

## Verification
With a zero tuning word, the phase sits at zero while the modulation code is stepped through all four values. This separates the four quarter-turn offsets and pins down the two-cycle latency. A word of one table step per clock walks every table entry in both directions, including the backward sweep through the accumulator wrap. This exposes errors in mirroring, the sign or the invert flag at each quadrant boundary. A large odd word, with the modulation code changed on every cycle, mixes carries from the low accumulator bits with offset changes. A reference model that runs one cycle apart would therefore miscompare quickly.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int ACC_W_DEF  = 32;
    localparam int OUT_W_DEF  = 10;
    localparam int ADDR_W_DEF = 8;

    // quarter-turn keying codes
    typedef enum logic [1:0] {
        PM_0   = 2'b00,
        PM_90  = 2'b01,
        PM_270 = 2'b10,
        PM_180 = 2'b11
    } pm_e;

    // number of quadrants a keying code advances the phase
    function automatic logic [1:0] quad_step(input logic [1:0] pm);
        logic [1:0] q;
        case (pm_e'(pm))
            PM_0:    q = 2'd0;
            PM_90:   q = 2'd1;
            PM_270:  q = 2'd3;
            default: q = 2'd2;
        endcase
        return q;
    endfunction

    // quarter-wave magnitude of table entry idx, sampled at half-step centres
    function automatic int mag_of(input int idx, input int aw, input int mw);
        real amp;
        real ang;
        amp = real'((1 << mw) - 1);
        ang = 1.5707963267948966 * (real'(idx) + 0.5) / real'(1 << aw);
        return $rtoi(amp * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/nco_phase.sv
module nco_phase #(
    parameter int ACC_W = nco_pkg::ACC_W_DEF,
    parameter int PH_W  = nco_pkg::ADDR_W_DEF + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tw_we,
    input  logic [ACC_W-1:0] tw_data,
    input  logic [1:0]       pm_code,
    output logic [ACC_W-1:0] tw_q,
    output logic [ACC_W-1:0] acc,
    output logic [1:0]       pm_q,
    output logic [PH_W-1:0]  phase
);
    localparam int FRAC_W = PH_W - 2;

    logic [PH_W-1:0] offset;

    // keying offset expressed in phase units of the truncated accumulator
    assign offset = {nco_pkg::quad_step(pm_q), {FRAC_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            tw_q  <= '0;
            acc   <= '0;
            pm_q  <= '0;
            phase <= '0;
        end else begin
            if (tw_we) begin
                tw_q <= tw_data;
            end
            acc   <= acc + tw_q;
            pm_q  <= pm_code;
            phase <= acc[ACC_W-1 -: PH_W] + offset;
        end
    end
endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom #(
    parameter int ADDR_W = nco_pkg::ADDR_W_DEF,
    parameter int MAG_W  = nco_pkg::OUT_W_DEF - 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [MAG_W-1:0]  mag
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [MAG_W-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [MAG_W-1:0] ENT = MAG_W'(nco_pkg::mag_of(i, ADDR_W, MAG_W));
        assign tbl[i] = ENT;
    end

    assign mag = tbl[addr];
endmodule

// File: rtl/nco_fold.sv
module nco_fold #(
    parameter int ADDR_W = nco_pkg::ADDR_W_DEF,
    parameter int MAG_W  = nco_pkg::OUT_W_DEF - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W+1:0] phase,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [MAG_W-1:0]  rom_mag,
    output logic [MAG_W:0]    code,
    output logic              inv
);
    typedef struct packed {
        logic [1:0]        quad;
        logic [ADDR_W-1:0] idx;
    } ph_t;

    localparam logic [MAG_W-1:0] REST_MAG = MAG_W'(nco_pkg::mag_of(0, ADDR_W, MAG_W));

    ph_t  ph;
    logic mirror;
    logic lower;

    assign ph       = phase;
    assign mirror   = ph.quad[0];
    assign lower    = ph.quad[1];
    assign rom_addr = mirror ? ~ph.idx : ph.idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= {1'b1, REST_MAG};
            inv  <= 1'b0;
        end else begin
            code <= {~lower, rom_mag};
            inv  <= lower;
        end
    end
endmodule

// File: rtl/qwave_nco.sv
module qwave_nco #(
    parameter int ACC_W  = nco_pkg::ACC_W_DEF,
    parameter int OUT_W  = nco_pkg::OUT_W_DEF,
    parameter int ADDR_W = nco_pkg::ADDR_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tw_we,
    input  logic [ACC_W-1:0] tw_data,
    input  logic [1:0]       pm_code,
    output logic [OUT_W-1:0] dac_code,
    output logic             dac_inv
);
    localparam int PH_W  = ADDR_W + 2;
    localparam int MAG_W = OUT_W - 1;

    logic [ACC_W-1:0]  tw_q;
    logic [ACC_W-1:0]  acc;
    logic [1:0]        pm_q;
    logic [PH_W-1:0]   phase;
    logic [ADDR_W-1:0] rom_addr;
    logic [MAG_W-1:0]  rom_mag;

    nco_phase #(.ACC_W(ACC_W), .PH_W(PH_W)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .tw_we   (tw_we),
        .tw_data (tw_data),
        .pm_code (pm_code),
        .tw_q    (tw_q),
        .acc     (acc),
        .pm_q    (pm_q),
        .phase   (phase)
    );

    nco_quarter_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
        .addr (rom_addr),
        .mag  (rom_mag)
    );

    nco_fold #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_fold (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .rom_addr (rom_addr),
        .rom_mag  (rom_mag),
        .code     (dac_code),
        .inv      (dac_inv)
    );
endmodule

// File: rtl/qwave_nco_chk.sv
module qwave_nco_chk #(
    parameter int ACC_W = 32,
    parameter int OUT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             tw_we,
    input logic [ACC_W-1:0] tw_data,
    input logic [ACC_W-1:0] tw_q,
    input logic [ACC_W-1:0] acc,
    input logic [1:0]       pm_q,
    input logic [OUT_W-1:0] dac_code,
    input logic             dac_inv
);
    // R2: a written word is held from the next cycle on
    assert_tw_load_R2: assert property (@(posedge clk) disable iff (rst)
        tw_we |=> tw_q == $past(tw_data));

    // R3: accumulator advances by the held word every clock
    assert_accumulate_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> acc == $past(acc) + $past(tw_q));

    // R6: invert flag and sign bit always disagree
    assert_sign_flag_R6: assert property (@(posedge clk) disable iff (rst)
        dac_inv != dac_code[OUT_W-1]);

    // R8: frozen phase and steady keying code give a steady output
    assert_steady_out_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(tw_q, 2) == '0 && $past(pm_q) == $past(pm_q, 2)) |=> $stable(dac_code));
endmodule

bind qwave_nco qwave_nco_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tw_we    (tw_we),
    .tw_data  (tw_data),
    .tw_q     (tw_q),
    .acc      (acc),
    .pm_q     (pm_q),
    .dac_code (dac_code),
    .dac_inv  (dac_inv)
);

// File: tb/qwave_nco_test.sv
module qwave_nco_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tw_we = 1'b0;
    logic [31:0] tw_data = '0;
    logic [1:0]  pm_code = 2'b00;
    logic [9:0]  dac_code;
    logic        dac_inv;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] acc_m = '0;
    logic [31:0] tw_m  = '0;
    logic [9:0]  expq[$];

    always #2 clk = ~clk;

    qwave_nco uut (
        .clk      (clk),
        .rst      (rst),
        .tw_we    (tw_we),
        .tw_data  (tw_data),
        .pm_code  (pm_code),
        .dac_code (dac_code),
        .dac_inv  (dac_inv)
    );

    function automatic logic [1:0] quarters(input logic [1:0] pm);
        case (pm)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            2'b10:   return 2'd3;
            default: return 2'd2;
        endcase
    endfunction

    function automatic int eff_of(input logic [9:0] c, input logic i);
        return i ? int'({c[9], ~c[8:0]}) : int'(c);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // driver side of the scoreboard: model phase per edge, push expectation
    always @(posedge clk) begin
        if (rst) begin
            acc_m = '0;
            tw_m  = '0;
            expq.delete();
        end else begin
            logic [31:0] nxt;
            nxt = acc_m + tw_m;
            if (tw_we) tw_m = tw_data;
            acc_m = nxt;
            expq.push_back(acc_m[31:22] + {quarters(pm_code), 8'b0});
        end
    end

    // monitor: item pushed at edge E is due after edge E+2 (R8)
    always @(negedge clk) begin
        if (!rst && expq.size() > 2) begin
            logic [9:0] p;
            real        ref_v;
            real        d;
            int         e;
            p     = expq.pop_front();
            ref_v = 511.5 + 511.5 * $sin(2.0 * 3.141592653589793 * (real'(p) + 0.5) / 1024.0);
            e     = eff_of(dac_code, dac_inv);
            d     = real'(e) - ref_v;
            if (d < 0.0) d = -d;
            // R4 R5 R7: offset, mirroring and table accuracy
            check(d <= 2.0, "R7 sine accuracy (R4 R5)", e, $rtoi(ref_v + 0.5));
            // R6: sign bit and invert flag from the half-cycle
            check(dac_code[9] == ~p[9] && dac_inv == p[9], "R6 sign/invert",
                  int'({dac_code[9], dac_inv}), int'({~p[9], p[9]}));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    logic [15:0] lf = 16'hACE1;

    initial begin
        tick(5);
        check(dac_code == 10'd514 && dac_inv == 1'b0, "R1 reset state",
              eff_of(dac_code, dac_inv), 514);
        rst = 1'b0;
        tick(3);
        check(dac_code == 10'd514, "R1 after reset", int'(dac_code), 514);

        // R8 latency of a keying change, then R4 at each code
        pm_code = 2'b01;
        tick(1);
        check(dac_code == 10'd514, "R8 no change at E", int'(dac_code), 514);
        tick(1);
        check(dac_code == 10'd514, "R8 no change at E+1", int'(dac_code), 514);
        tick(1);
        check(eff_of(dac_code, dac_inv) == 1023, "R8 R4 quarter turn at E+2",
              eff_of(dac_code, dac_inv), 1023);
        pm_code = 2'b11;
        tick(3);
        check(eff_of(dac_code, dac_inv) == 509, "R4 half turn",
              eff_of(dac_code, dac_inv), 509);
        pm_code = 2'b10;
        tick(3);
        check(dac_code == 10'h1FF && dac_inv == 1'b1, "R4 three quarter turn",
              eff_of(dac_code, dac_inv), 0);
        pm_code = 2'b00;
        tick(3);
        check(dac_code == 10'd514, "R4 zero offset", int'(dac_code), 514);

        // R2 load timing, R3 per-clock accumulation
        tw_we   = 1'b1;
        tw_data = 32'h0040_0000;
        tick(1);
        tw_we = 1'b0;
        tick(2);
        check(dac_code == 10'd514, "R2 word not yet in output", int'(dac_code), 514);
        tick(1);
        check(dac_code == 10'd517, "R2 first step", int'(dac_code), 517);
        tick(1);
        check(dac_code == 10'd520, "R3 second step", int'(dac_code), 520);

        // full forward sweep, one table step per clock
        tick(1100);

        // backwards through the wrap (R3)
        tw_we   = 1'b1;
        tw_data = 32'hFFC0_0000;
        tick(1);
        tw_we = 1'b0;
        tick(1100);

        // large odd word with keying code changing every cycle
        tw_we   = 1'b1;
        tw_data = 32'h3A5C_1234;
        tick(1);
        tw_we = 1'b0;
        for (int n = 0; n < 1500; n++) begin
            lf      = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            pm_code = lf[1:0];
            if (n % 97 == 0) begin
                tw_we   = 1'b1;
                tw_data = {lf, lf ^ 16'h5A5A};
            end else begin
                tw_we = 1'b0;
            end
            tick(1);
        end
        tw_we = 1'b0;
        tick(4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule